// File: doc/BRIEF.md
# Inter-core mailbox register bank

A bank of 32-bit mailboxes through which processor cores signal each other. Each core owns a fixed group of mailboxes. A sender posts flags into a target mailbox by writing to its set alias; every written one bit is ORed into the stored word. The receiver reads the mailbox through its clear alias, then writes back the bits it has handled to clear them.

Each mailbox drives a registered pending flag that is high whenever the stored word is nonzero. The flags for one core are grouped into a contiguous vector, so an interrupt router can turn them into per-core interrupts. The bus side is a plain single-cycle interface: a write strobe, a read strobe, a word address and data. Read data appears one cycle after the read strobe.

Top module: `mbox_bank`

## Requirements
- R1: After reset every mailbox holds zero, `pend_o` is all zero and `rdata_o` is zero.
- R2: A write to byte address 0x80 + 4·i, for i = core·4 + box in 0..15, ORs `wdata_i` into mailbox i. No other mailbox changes.
- R3: A write to byte address 0xC0 + 4·i clears every bit of mailbox i that is 1 in `wdata_i` and leaves its other bits unchanged. No other mailbox changes.
- R4: A read of byte address 0xC0 + 4·i places the contents of mailbox i on `rdata_o` on the clock edge that samples `rd_en_i`. The value stays there until the next read.
- R5: A read of the set window (0x80–0xBF), or of any address below 0x80, returns zero.
- R6: A write to any address below 0x80 changes no mailbox.
- R7: `pend_o[i]` is 1 exactly when mailbox i is nonzero. Bits [4c+3:4c] belong to core c. The flag changes on the same clock edge that writes the mailbox.
- R8: Address bits [1:0] are ignored, so every access is a full-word access.
- R9: When a read and a write hit the same mailbox in the same cycle, the read returns the value the mailbox held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe, one access per cycle |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| pend_o | output | 16 | Per-mailbox nonzero flags, core-major |

## Verification
The bench builds the block with its default parameters: four cores with four mailboxes each, 32-bit data, the set window at 0x80 and the clear window at 0xC0. The address space is then only 256 bytes, so random addresses regularly land in every mailbox of both windows, on the first and last words of each window, and in the unmapped low region. Sparse random data makes partial clears and mailboxes returning to zero common, which moves each pending flag in both directions.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NBOX     = 16,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0,
  localparam int IDX_W   = $clog2(NBOX)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output win_e              win_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int WIN_BYTES = NBOX * 4;
  localparam logic [ADDR_W:0] SET_LO = (ADDR_W+1)'(SET_BASE);
  localparam logic [ADDR_W:0] SET_HI = (ADDR_W+1)'(SET_BASE + WIN_BYTES);
  localparam logic [ADDR_W:0] CLR_LO = (ADDR_W+1)'(CLR_BASE);
  localparam logic [ADDR_W:0] CLR_HI = (ADDR_W+1)'(CLR_BASE + WIN_BYTES);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] offs;
  assign a_ext = {1'b0, addr_i};

  always_comb begin
    win_o = WIN_NONE;
    offs  = '0;
    if (a_ext >= SET_LO && a_ext < SET_HI) begin
      win_o = WIN_SET;
      offs  = a_ext - SET_LO;
    end else if (a_ext >= CLR_LO && a_ext < CLR_HI) begin
      win_o = WIN_CLR;
      offs  = a_ext - CLR_LO;
    end
  end

  // low two bits dropped: word access only
  assign idx_o = offs[IDX_W+1:2];
endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] val_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] val_q, val_d;
  logic              pend_q;

  always_comb begin
    val_d = val_q;
    if (clr_i) val_d = val_d & ~wdata_i;
    if (set_i) val_d = val_d | wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      val_q  <= val_d;
      pend_q <= |val_d;
    end
  end

  assign val_o  = val_q;
  assign pend_o = pend_q;

  // R2
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((val_q & $past(wdata_i)) == $past(wdata_i)));
  // R3
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((val_q & $past(wdata_i)) == '0));
  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(val_q));
  // R7
  pend_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q == (val_q != '0));
endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NBOX   = 16,
  localparam int IDX_W = $clog2(NBOX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  win_e              win_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] vals_i [NBOX],
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= (win_i == WIN_CLR) ? vals_i[idx_i] : '0;
  end

  assign rdata_o = rdata_q;

  // R5
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && win_i != WIN_CLR) |=> (rdata_q == '0));
  // R4
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CORES      = 4,
  parameter int BOXES_PER_CORE = 4,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 8,
  parameter int SET_BASE       = 'h80,
  parameter int CLR_BASE       = 'hC0,
  localparam int NBOX          = NUM_CORES * BOXES_PER_CORE,
  localparam int IDX_W         = $clog2(NBOX)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NBOX-1:0]   pend_o
);
  win_e             win;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] vals [NBOX];

  mbox_decode #(
    .ADDR_W(ADDR_W), .NBOX(NBOX), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr_i(addr_i), .win_o(win), .idx_o(idx)
  );

  for (genvar g = 0; g < NBOX; g++) begin : g_box
    logic hit;
    assign hit = wr_en_i && (idx == IDX_W'(g));
    mbox_cell #(.DATA_W(DATA_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (hit && win == WIN_SET),
      .clr_i  (hit && win == WIN_CLR),
      .wdata_i(wdata_i),
      .val_o  (vals[g]),
      .pend_o (pend_o[g])
    );
  end

  mbox_rd_mux #(.DATA_W(DATA_W), .NBOX(NBOX)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .win_i  (win),
    .idx_i  (idx),
    .vals_i (vals),
    .rdata_o(rdata_o)
  );

  // R6
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && win == WIN_NONE) |=> $stable(pend_o));
  // R1
  reset_pend_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (pend_o == '0 && rdata_o == '0));
endmodule

// File: tb/sim_mbox_bank.sv
module sim_mbox_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] pend;

  int n_tests = 0, n_fail = 0;
  logic [31:0] mdl [16];

  always #2.5 clk = ~clk;

  mbox_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend)
  );

  function automatic logic [15:0] exp_pend();
    logic [15:0] p;
    for (int i = 0; i < 16; i++) p[i] = (mdl[i] != 0);
    return p;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a >= 8'hC0) return mdl[(a - 8'hC0) >> 2];
    return 32'h0;
  endfunction

  function automatic void mdl_write(logic [7:0] a, logic [31:0] d);
    if (a >= 8'hC0)      mdl[(a - 8'hC0) >> 2] &= ~d;
    else if (a >= 8'h80) mdl[(a - 8'h80) >> 2] |= d;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl_write(a, d);
    check(req, {16'h0, pend}, {16'h0, exp_pend()});
  endtask

  task automatic rd(logic [7:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    e = exp_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd4242));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pend", {16'h0, pend}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rst_n = 1'b1;
    rd(8'hC0, "R1 read box0");
    rd(8'hFC, "R1 read box15");

    // R2 / R7 directed: core 2 box 3 -> index 11
    wr(8'hAC, 32'h0000_00F0, "R7 core2 box3 pend");
    rd(8'hEC, "R2 set index 11");
    wr(8'hAC, 32'h0000_0003, "R2 OR accumulate");
    rd(8'hEC, "R2 accumulated value");
    // R3 partial and full clear
    wr(8'hEC, 32'h0000_0011, "R3 partial clear pend");
    rd(8'hEC, "R3 partial clear value");
    wr(8'hEC, 32'hFFFF_FFFF, "R7 pend falls at clear");
    rd(8'hEC, "R3 full clear value");
    // R5 set window and low region read zero
    wr(8'h80, 32'hDEAD_BEEF, "R2 box0 set");
    rd(8'h80, "R5 set window read");
    rd(8'h10, "R5 unmapped read");
    // R6 unmapped writes
    wr(8'h00, 32'hFFFF_FFFF, "R6 unmapped write pend");
    wr(8'h7C, 32'hFFFF_FFFF, "R6 unmapped write pend edge");
    for (int i = 0; i < 16; i++) rd(8'hC0 + 8'(i * 4), "R6 all boxes intact");
    // R8 low address bits ignored
    wr(8'hBF, 32'h8000_0001, "R8 set alias low bits");
    rd(8'hFD, "R8 read alias low bits");
    wr(8'hFE, 32'h0000_0001, "R8 clear alias low bits");
    rd(8'hFC, "R8 clear applied");
    // R9 read and write same cycle
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'hC0; wdata = 32'hFFFF_0000;
    e = exp_read(8'hC0);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    mdl_write(8'hC0, 32'hFFFF_0000);
    check("R9 read sees old value", rdata, e);
    rd(8'hC0, "R9 write applied");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int kind;
      kind = $urandom_range(0, 9);
      d = $urandom & $urandom & $urandom;
      if (kind < 4)      a = 8'h80 | 8'($urandom_range(0, 63));
      else if (kind < 7) a = 8'hC0 | 8'($urandom_range(0, 63));
      else               a = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 2) == 0) rd(a, "R4 random read");
      else wr(a, d, "R7 random write pend");
    end
    for (int i = 0; i < 16; i++) rd(8'hC0 + 8'(i * 4), "R4 final contents");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule